// File: doc/BRIEF.md
# Justified Pixel Pulse-Width Generator

This block turns a stream of pixel codes into one output pulse per dot period, for driving a modulated light source such as a printer laser. Each dot period is divided into 2^CODE_W ticks of a fast clock. A dot strobe marks the first tick of every period. The pulse width is the code value in ticks. A placement input selects where the pulse sits in the period: at the start, at the end, or centred.

A pulse that ends on a period boundary, followed by a pulse that starts on that boundary, gives one unbroken high level. Code and placement pass through two register stages, clocked by the dot strobe, before they shape a period. A retrace input overrides the code and holds the output high. A run input, when low, puts the block into a reduced-power state. In that state the tick counter and the pipeline are frozen and the output is held low.

Top module: `pixel_pwm`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` is 0. Reset loads code 0 into both pipeline stages, so the first period after reset stays low for every tick.
- R2: A strobe sampled at a clock edge, with `pwr_run_i` high, restarts the tick count at 0, even in the middle of a period. Each later edge without a strobe advances the tick count by one.
- R3: At a strobe edge, the code and placement on `code_i` and `mode_i` are captured. They shape the period that starts at the following strobe, one full period later.
- R4: Code 0 keeps `pwm_o` low for the whole period.
- R5: The all-ones code (2^CODE_W-1) keeps `pwm_o` high for all 2^CODE_W ticks. Any other code w gives exactly w high ticks.
- R6: Placement 2'b00 (left) drives the output high on ticks 0 to w-1.
- R7: Placement 2'b01 (right) drives the output high on ticks 2^CODE_W-w to 2^CODE_W-1.
- R8: Placements 2'b10 and 2'b11 (centre) drive the output high on w ticks, starting at tick floor((2^CODE_W-w)/2). An odd spare tick therefore falls on the trailing side.
- R9: A right-placed pulse followed by a left-placed pulse gives no low tick across the boundary between the two periods.
- R10: With `pwr_run_i` high, `retrace_i`=1 sampled at an edge makes `pwm_o` 1 after that edge, whatever the code. Once retrace returns to 0, the output follows the code again at the current tick.
- R11: `pwr_run_i`=0 sampled at an edge makes `pwm_o` 0 after that edge, even when retrace is 1. While it is low, the tick count and both stages hold and strobes are ignored. Operation resumes from the held tick.
- R12: `pwm_o` comes from a register. In the t-th cycle after a strobe edge (t=0 first), it shows the level for tick t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_i | input | 1 | Dot-period strobe, one cycle wide |
| code_i | input | CODE_W | Pixel code |
| mode_i | input | 2 | Pulse placement: 00 left, 01 right, 10/11 centre |
| retrace_i | input | 1 | Forces the output high |
| pwr_run_i | input | 1 | 1 runs normally, 0 enters reduced power |
| pwm_o | output | 1 | Registered pulse output |

## Verification
Retrace and reduced power can both be active on the same edge, and a dot strobe can arrive while the block is frozen. The bench stops a left-placed period partway through. During the pause it holds retrace high, pulses the strobe every cycle and presents a different code. It expects the output to stay low throughout. It then expects the period to resume at the held tick, and the next period to show the code captured before the pause.

// File: rtl/pixel_pwm_pkg.sv
package pixel_pwm_pkg;
  typedef enum logic [1:0] {
    PLACE_LEFT   = 2'b00,
    PLACE_RIGHT  = 2'b01,
    PLACE_CENTER = 2'b10,
    PLACE_CALT   = 2'b11
  } place_e;
endpackage

// File: rtl/pixel_pwm_tick.sv
module pixel_pwm_tick #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             dot_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (!run_i)     cnt_nxt_o = cnt_q;
    else if (dot_i) cnt_nxt_o = '0;
    else            cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pixel_pwm_pipe.sv
module pixel_pwm_pipe
  import pixel_pwm_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] code_i,
  input  place_e            mode_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_nxt_o,
  output logic [CODE_W-1:0] code_feed_o,
  output place_e            mode_o,
  output place_e            mode_nxt_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [CODE_W-1:0] code_q [STAGES];
  place_e            mode_q [STAGES];
  place_e            mode_feed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) begin
        code_q[i] <= '0;
        mode_q[i] <= PLACE_LEFT;
      end
    end else if (adv_i) begin
      code_q[0] <= code_i;
      mode_q[0] <= mode_i;
      for (int i = 1; i < STAGES; i++) begin
        code_q[i] <= code_q[i-1];
        mode_q[i] <= mode_q[i-1];
      end
    end
  end

  // value entering the last stage on an advance
  generate
    if (STAGES == 1) begin : g_single
      assign code_feed_o = code_i;
      assign mode_feed   = mode_i;
    end else begin : g_multi
      assign code_feed_o = code_q[LAST-1];
      assign mode_feed   = mode_q[LAST-1];
    end
  endgenerate

  assign code_o     = code_q[LAST];
  assign mode_o     = mode_q[LAST];
  assign code_nxt_o = adv_i ? code_feed_o : code_q[LAST];
  assign mode_nxt_o = adv_i ? mode_feed   : mode_q[LAST];
endmodule

// File: rtl/pixel_pwm_shape.sv
module pixel_pwm_shape
  import pixel_pwm_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] tick_i,
  input  logic [CODE_W-1:0] code_i,
  input  place_e            mode_i,
  output logic              hi_o
);
  localparam int unsigned EW = CODE_W + 2;
  localparam logic [EW-1:0] TICKS = EW'(1) << CODE_W;

  logic [EW-1:0] width, tick, start, stop;

  always_comb begin
    width = (&code_i) ? TICKS : {2'b00, code_i};
    tick  = {2'b00, tick_i};
    start = (TICKS - width) >> 1;
    stop  = start + width;
    unique case (mode_i)
      PLACE_LEFT:  hi_o = tick < width;
      PLACE_RIGHT: hi_o = (tick + width) >= TICKS;
      default:     hi_o = (tick >= start) && (tick < stop);
    endcase
  end
endmodule

// File: rtl/pixel_pwm.sv
module pixel_pwm
  import pixel_pwm_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dot_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        mode_i,
  input  logic              retrace_i,
  input  logic              pwr_run_i,
  output logic              pwm_o
);
  logic [CODE_W-1:0] tick_q, tick_nxt;
  logic [CODE_W-1:0] code_cur, code_nxt, code_feed;
  place_e            mode_cur, mode_nxt;
  logic              adv, hi, pwm_d;

  assign adv = pwr_run_i & dot_i;

  pixel_pwm_tick #(.CNT_W(CODE_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (pwr_run_i),
    .dot_i     (dot_i),
    .cnt_o     (tick_q),
    .cnt_nxt_o (tick_nxt)
  );

  pixel_pwm_pipe #(.CODE_W(CODE_W), .STAGES(STAGES)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .code_i      (code_i),
    .mode_i      (place_e'(mode_i)),
    .code_o      (code_cur),
    .code_nxt_o  (code_nxt),
    .code_feed_o (code_feed),
    .mode_o      (mode_cur),
    .mode_nxt_o  (mode_nxt)
  );

  // shape from next-state so the register lines up with the tick count
  pixel_pwm_shape #(.CODE_W(CODE_W)) u_shape (
    .tick_i (tick_nxt),
    .code_i (code_nxt),
    .mode_i (mode_nxt),
    .hi_o   (hi)
  );

  always_comb begin
    if (!pwr_run_i)     pwm_d = 1'b0;
    else if (retrace_i) pwm_d = 1'b1;
    else                pwm_d = hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 1'b0;
    else         pwm_o <= pwm_d;
  end
endmodule

// File: rtl/pixel_pwm_chk.sv
module pixel_pwm_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dot_i,
  input logic              retrace_i,
  input logic              pwr_run_i,
  input logic              pwm_o,
  input logic [CODE_W-1:0] tick,
  input logic [CODE_W-1:0] code_cur,
  input logic [CODE_W-1:0] code_feed
);
  localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

  AST_RESET_LOW: assert property (@(posedge clk_i) !rst_ni |-> !pwm_o); // R1

  AST_STROBE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_run_i && dot_i |=> tick == '0); // R2

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_run_i && !dot_i |=> tick == CODE_W'($past(tick) + 1'b1)); // R2

  AST_PIPE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_run_i && dot_i |=> code_cur == $past(code_feed)); // R3

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_cur == '0) && $past(pwr_run_i) && !$past(retrace_i) |-> !pwm_o); // R4

  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_cur == MAXC) && $past(pwr_run_i) && !$past(retrace_i) |-> pwm_o); // R5

  AST_RETRACE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_run_i && retrace_i |=> pwm_o); // R10

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_run_i |=> !pwm_o); // R11

  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_run_i |=> $stable(tick) && $stable(code_cur)); // R11
endmodule

bind pixel_pwm pixel_pwm_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dot_i     (dot_i),
  .retrace_i (retrace_i),
  .pwr_run_i (pwr_run_i),
  .pwm_o     (pwm_o),
  .tick      (tick_q),
  .code_cur  (code_cur),
  .code_feed (code_feed)
);

// File: tb/tb_pixel_pwm.sv
`timescale 1ns/1ps
module tb_pixel_pwm;
  localparam int CW = 4;
  localparam int T  = 1 << CW;
  localparam int MAXC = T - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dot = 1'b0;
  logic [CW-1:0] code = '0;
  logic [1:0] mode = 2'b00;
  logic retr = 1'b0;
  logic run = 1'b1;
  logic pwm;

  int checks = 0;
  int errors = 0;
  int pc = 0;
  int pm = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_pwm #(.CODE_W(CW), .STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dot_i(dot), .code_i(code), .mode_i(mode),
    .retrace_i(retr), .pwr_run_i(run), .pwm_o(pwm)
  );

  function automatic logic model(int t, int c, int m);
    int w = (c == MAXC) ? T : c;
    int s = (T - w) / 2;
    case (m)
      0:       return t < w;
      1:       return t >= T - w;
      default: return (t >= s) && (t < s + w);
    endcase
  endfunction

  function automatic string req_of(int c, int m);
    if (c == 0)    return "R4";
    if (c == MAXC) return "R5";
    if (m == 0)    return "R6";
    if (m == 1)    return "R7";
    return "R8";
  endfunction

  task automatic check(input logic exp, input string tag);
    checks++;
    if (pwm !== exp) begin
      errors++;
      $display("FAIL %s: pwm_o=%b expected %b", tag, pwm, exp);
    end
  endtask

  task automatic step(input logic d, input int c, input int m, input logic r,
                      input logic rn, input logic exp, input string tag);
    @(negedge clk);
    dot = d; code = CW'(c); mode = 2'(m); retr = r; run = rn;
    @(posedge clk);
    #1;
    check(exp, tag);
  endtask

  // full period with strobe on tick 0; active code is the one captured a strobe earlier
  task automatic period(input int c, input int m, input string pre);
    int uc = pc;
    int um = pm;
    for (int t = 0; t < T; t++)
      step(t == 0, c, m, 1'b0, 1'b1, model(t, uc, um),
           $sformatf("%s R3 R12 %s code=%0d mode=%0d tick=%0d", pre, req_of(uc, um), uc, um, t));
    pc = c; pm = m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 during reset");
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: first period after reset runs on the cleared stage
    period(MAXC, 0, "R1");

    // sweep every code and placement
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < T; c++)
        period(c, m, "sweep");

    // R2: early strobe restarts the count
    period(8, 0, "R2 prep");
    period(8, 0, "R2 prep");
    for (int t = 0; t < 6; t++)
      step(t == 0, 8, 0, 1'b0, 1'b1, model(t, 8, 0), "R2 before restart");
    for (int t = 0; t < T; t++)
      step(t == 0, 8, 0, 1'b0, 1'b1, model(t, 8, 0), $sformatf("R2 after restart tick=%0d", t));

    // R9: right then left gives a continuous level across the boundary
    period(12, 1, "R9 load");
    period(9, 0, "R9 right");
    period(0, 0, "R9 left");

    // R10: retrace over a code-0 period
    period(0, 0, "R10 prep");
    for (int t = 0; t < T; t++)
      step(t == 0, 0, 0, (t >= 4 && t < 8), 1'b1, (t >= 4 && t < 8),
           $sformatf("R10 tick=%0d", t));
    pc = 0; pm = 0;

    // R11: pause mid-period with retrace and strobes active
    period(8, 0, "R11 prep");
    period(8, 0, "R11 prep");
    for (int t = 0; t < 4; t++)
      step(t == 0, 8, 0, 1'b0, 1'b1, model(t, 8, 0), "R11 before pause");
    for (int k = 0; k < 5; k++)
      step(1'b1, 3, 1, 1'b1, 1'b0, 1'b0, "R11 paused with retrace");
    for (int t = 4; t < T; t++)
      step(1'b0, 8, 0, 1'b0, 1'b1, model(t, 8, 0), $sformatf("R11 resume tick=%0d", t));
    pc = 8; pm = 0;
    period(5, 2, "R11 stages held");
    period(0, 0, "R8 flush");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule